// File: doc/BRIEF.md
# Bit-Sliced Six-Function ALU

This block is a purely combinational integer ALU of parameterised width. It is built from a row of identical one-bit cells joined by a ripple carry. Each cell holds three pieces of logic: a full adder, a two-input AND and a two-input OR. Each cell can optionally invert either operand before that logic sees it, and an output selector picks which result leaves the cell.

One small function code picks the operation: addition, subtraction, signed set-less-than, AND, OR or NOR. Subtraction reuses the adder: the second operand is inverted and the carry into bit 0 is forced high. NOR reuses the AND gate with both operands inverted. Set-less-than performs a subtraction and returns the sign of the true difference in bit 0.

The top cell also produces the signed overflow and the less-than decision. A flag reports an all-zero result.

Top module: `alu_bitslice`

## Requirements
- R1: With function code 4'b0010 (add), `res_o` equals `a_i + b_i` modulo 2^WIDTH, and `cout_o` is the unsigned carry out of the top bit.
- R2: With function code 4'b0110 (subtract), `res_o` equals `a_i - b_i` modulo 2^WIDTH, and `cout_o` is 1 exactly when `a_i >= b_i` as unsigned numbers (no borrow).
- R3: For function codes 4'b0010 and 4'b0110, `ovf_o` is 1 exactly when the two's-complement result of the add or subtract does not fit in WIDTH bits.
- R4: With function code 4'b0111 (set-less-than), `res_o` is 1 when `a_i < b_i` as signed two's-complement numbers and 0 otherwise, with all upper bits 0. This holds even when `a_i - b_i` overflows.
- R5: With function code 4'b0000, `res_o` is the bitwise AND of the operands.
- R6: With function code 4'b0001, `res_o` is the bitwise OR of the operands.
- R7: With function code 4'b1100, `res_o` is the bitwise NOR of the operands.
- R8: `zero_o` is 1 exactly when every bit of `res_o` is 0, for every function code.
- R9: The block holds no state. Outputs follow the inputs within the same clock period, for every function code. The function code is laid out as {invert A, invert B, select[1:0]}, where select 00 is AND, 01 is OR, 10 is the adder sum and 11 is less-than.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| fn_i | input | 4 | Function code {invert A, invert B, select[1:0]} |
| res_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when the result is all zeros |
| cout_o | output | 1 | Carry out of the top cell (add/subtract) |
| ovf_o | output | 1 | Signed overflow of the top cell (add/subtract) |

## Verification
The zero flag and the signed overflow can be raised by the same operation. Adding the most negative value to itself wraps to zero while also overflowing and carrying out, and subtracting the most negative value from a positive value near the top of the range overflows without carrying. Directed vectors provoke both coincidences, and random vectors add many more. For each vector, the bench judges the result, the zero flag, the carry and the overflow separately against its own wide-arithmetic model. Set-less-than is also driven with operands whose difference overflows, so that returning only the raw sign bit would be caught.

// File: rtl/alu_pkg.sv
// Package: shared function-code fields and named codes for the sliced ALU.
// Assumes a 4-bit code laid out as {invert A, invert B, select[1:0]}.
package alu_pkg;
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic     inv_a;
        logic     inv_b;
        alu_sel_e sel;
    } alu_fn_t;

    localparam logic [3:0] FN_AND = 4'b0000;
    localparam logic [3:0] FN_OR  = 4'b0001;
    localparam logic [3:0] FN_ADD = 4'b0010;
    localparam logic [3:0] FN_SUB = 4'b0110;
    localparam logic [3:0] FN_SLT = 4'b0111;
    localparam logic [3:0] FN_NOR = 4'b1100;
endpackage

// File: rtl/alu_cell.sv
// One-bit ALU cell: optional operand inversion, full adder, AND, OR and an
// output selector. Assumes the less-than input is driven only into bit 0.
module alu_cell
    import alu_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     inv_a_i,
    input  logic     inv_b_i,
    input  logic     cin_i,
    input  logic     less_i,
    input  alu_sel_e sel_i,
    output logic     res_o,
    output logic     cout_o,
    output logic     sum_o
);
    logic a_eff;
    logic b_eff;

    // Condition the operands and form the full-adder outputs.
    always_comb begin
        a_eff  = a_i ^ inv_a_i;
        b_eff  = b_i ^ inv_b_i;
        sum_o  = a_eff ^ b_eff ^ cin_i;
        cout_o = (a_eff & b_eff) | (cin_i & (a_eff ^ b_eff));
    end

    // Pick the cell output from the logic, adder or less-than path.
    always_comb begin
        unique case (sel_i)
            SEL_AND: res_o = a_eff & b_eff;
            SEL_OR:  res_o = a_eff | b_eff;
            SEL_SUM: res_o = sum_o;
            default: res_o = less_i;
        endcase
    end
endmodule

// File: rtl/alu_top_flags.sv
// Top-cell flag logic: signed overflow from the carries around the top
// cell, and the true signed less-than decision (sign corrected by overflow).
module alu_top_flags (
    input  logic top_sum_i,
    input  logic top_cin_i,
    input  logic top_cout_i,
    output logic ovf_o,
    output logic set_o
);
    // Derive overflow and the corrected sign of the difference.
    always_comb begin
        ovf_o = top_cin_i ^ top_cout_i;
        set_o = top_sum_i ^ ovf_o;
    end
endmodule

// File: rtl/alu_zero_detect.sv
// Zero detector: high when every bit of the presented word is 0.
module alu_zero_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             zero_o
);
    // Reduce the whole word with a NOR.
    always_comb zero_o = ~|word_i;
endmodule

// File: rtl/alu_bitslice.sv
// Ripple-carry ALU built from WIDTH identical one-bit cells. Purely
// combinational. Assumes WIDTH >= 2. The carry into bit 0 equals the
// invert-B field, so subtract and set-less-than add ~b + 1.
module alu_bitslice
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       fn_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    alu_fn_t          fn;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] less;
    logic             set_w;

    // Split the function code into its fields and seed the carry chain.
    always_comb begin
        fn       = alu_fn_t'(fn_i);
        carry[0] = fn.inv_b;
        less     = {{(WIDTH-1){1'b0}}, set_w};
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        alu_cell u_cell (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (fn.inv_a),
            .inv_b_i (fn.inv_b),
            .cin_i   (carry[i]),
            .less_i  (less[i]),
            .sel_i   (fn.sel),
            .res_o   (res_o[i]),
            .cout_o  (carry[i+1]),
            .sum_o   (sum[i])
        );
    end

    alu_top_flags u_flags (
        .top_sum_i  (sum[MSB]),
        .top_cin_i  (carry[MSB]),
        .top_cout_i (carry[WIDTH]),
        .ovf_o      (ovf_o),
        .set_o      (set_w)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word_i (res_o),
        .zero_o (zero_o)
    );

    // Expose the carry out of the top cell.
    always_comb cout_o = carry[WIDTH];
endmodule

// File: rtl/alu_bitslice_chk.sv
// Checker for alu_bitslice: immediate assertions on the port values,
// evaluated whenever the combinational outputs settle.
module alu_bitslice_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [3:0]       fn_i,
    input logic [WIDTH-1:0] res_o,
    input logic             zero_o,
    input logic             cout_o,
    input logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_add;
    logic [WIDTH:0] wide_sub;

    // Reference sums in one extra bit, then check each operation.
    always_comb begin
        wide_add = {1'b0, a_i} + {1'b0, b_i};
        wide_sub = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};
        assert_zero_flag_R8: assert (zero_o == (res_o == '0))
            else $error("zero flag mismatch");
        if (fn_i == FN_ADD) begin
            assert_add_sum_R1: assert ({cout_o, res_o} == wide_add)
                else $error("add mismatch");
            assert_add_ovf_R3: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB])))
                else $error("add overflow mismatch");
        end
        if (fn_i == FN_SUB) begin
            assert_sub_diff_R2: assert ({cout_o, res_o} == wide_sub)
                else $error("sub mismatch");
            assert_sub_ovf_R3: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB])))
                else $error("sub overflow mismatch");
        end
        if (fn_i == FN_SLT) begin
            assert_slt_value_R4: assert (res_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
                else $error("slt mismatch");
        end
        if (fn_i == FN_AND) begin
            assert_and_R5: assert (res_o == (a_i & b_i)) else $error("and mismatch");
        end
        if (fn_i == FN_OR) begin
            assert_or_R6: assert (res_o == (a_i | b_i)) else $error("or mismatch");
        end
        if (fn_i == FN_NOR) begin
            assert_nor_R7: assert (res_o == ~(a_i | b_i)) else $error("nor mismatch");
        end
    end
endmodule

bind alu_bitslice alu_bitslice_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .fn_i   (fn_i),
    .res_o  (res_o),
    .zero_o (zero_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o)
);

// File: tb/alu_bitslice_test.sv
// Bench for alu_bitslice: directed corners plus seeded random vectors,
// compared against a wide-arithmetic model held in bench functions.
module alu_bitslice_test;
    localparam int W   = 8;
    localparam int MSB = W - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b, res;
    logic [3:0]   fn;
    logic         zero, cout, ovf;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    alu_bitslice #(.WIDTH(W)) uut (
        .a_i(a), .b_i(b), .fn_i(fn),
        .res_o(res), .zero_o(zero), .cout_o(cout), .ovf_o(ovf)
    );

    // Model: returns {carry, overflow, result}.
    function automatic logic [W+1:0] model(input logic [3:0] f, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         v;
        s = {1'b0, x} + {1'b0, y};
        v = (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]);
        r = '0;
        case (f)
            4'b0010: r = s[W-1:0];
            4'b0110, 4'b0111: begin
                s = {1'b0, x} - {1'b0, y};
                s[W] = (x >= y);
                v = (x[MSB] != y[MSB]) && (s[MSB] != x[MSB]);
                r = (f == 4'b0110) ? s[W-1:0] : {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
            end
            4'b0000: r = x & y;
            4'b0001: r = x | y;
            4'b1100: r = ~(x | y);
            default: r = '0;
        endcase
        return {s[W], v, r};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (fn=%b a=%0h b=%0h)", tag, act, exp, fn, a, b);
        end
    endtask

    // Apply one vector on the falling edge and judge it before the next rise.
    task automatic apply(input logic [3:0] f, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W+1:0] e;
        string        tag;
        @(negedge clk);
        fn = f; a = x; b = y;
        #1;
        e = model(f, x, y);
        case (f)
            4'b0010: tag = "R1";
            4'b0110: tag = "R2";
            4'b0111: tag = "R4";
            4'b0000: tag = "R5";
            4'b0001: tag = "R6";
            default: tag = "R7";
        endcase
        chk({tag, " result (R9 same period)"}, 32'(res), 32'(e[W-1:0]));
        chk("R8 zero", 32'(zero), 32'(e[W-1:0] == '0));
        if (f == 4'b0010 || f == 4'b0110) begin
            chk({tag, " carry"}, 32'(cout), 32'(e[W+1]));
            chk("R3 overflow", 32'(ovf), 32'(e[W]));
        end
    endtask

    initial begin
        logic [3:0] ops [6];
        ops = '{4'b0010, 4'b0110, 4'b0111, 4'b0000, 4'b0001, 4'b1100};
        void'($urandom(32'd20240611));
        fn = 4'b0000; a = '0; b = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R8 idle zero", 32'(zero), 32'd1);
        chk("R5 idle result", 32'(res), 32'd0);
        // Directed corners.
        apply(4'b0010, 8'h7F, 8'h01);   // R3 positive overflow
        apply(4'b0010, 8'h80, 8'h80);   // R1 R3 R8 zero, carry and overflow together
        apply(4'b0010, 8'hFF, 8'h01);   // R1 carry with zero, no overflow
        apply(4'b0110, 8'h05, 8'h05);   // R2 zero, no borrow
        apply(4'b0110, 8'h02, 8'h05);   // R2 borrow
        apply(4'b0110, 8'h7F, 8'h80);   // R3 sub overflow
        apply(4'b0111, 8'h80, 8'h01);   // R4 overflowing difference, true
        apply(4'b0111, 8'h7F, 8'h80);   // R4 overflowing difference, false
        apply(4'b0111, 8'h03, 8'h03);   // R4 equal
        apply(4'b0111, 8'hFE, 8'h05);   // R4 negative below positive
        apply(4'b1100, 8'h00, 8'h00);   // R7 all ones
        apply(4'b1100, 8'hF0, 8'h0F);   // R7 zero result
        apply(4'b0000, 8'hAA, 8'h55);   // R5
        apply(4'b0001, 8'hA0, 8'h05);   // R6
        for (int i = 0; i < 3000; i++) begin
            apply(ops[$urandom_range(0, 5)], W'($urandom), W'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R9: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule